// File: doc/BRIEF.md
# Programmable AND / Fixed-OR Product-Term Array

This block is the logic core of a small programmable logic device. A set of logic inputs is buffered into true and inverted rails, and each rail becomes one column of a programmable AND plane. Every row of the plane is a product term. A connection bit in each row decides whether a column takes part in that row's AND. The full set of rows is evaluated combinationally, and the rows are then grouped for a row of macrocells. Each macrocell gets a fixed OR of its sum terms, plus one term that drives an asynchronous reset and one that drives its clock or output enable.

The connection map is held in on-block flops. A host loads it one row per clock through a row address and a row-wide data word, and can clear it in a single cycle. The registers, pin drivers and output enables of the macrocells are built elsewhere and consume the grouped terms. With the default parameters there are 20 inputs, which give 40 columns. There are 16 macrocells of 10 rows each, which gives 160 rows.

Top module: `pal_and_or_array`

## Requirements
- R1: After reset every connection bit is unprogrammed, so every product term, every macrocell sum, reset term and clock/enable term reads 1 whatever the inputs are.
- R2: Column 2*i carries input i unchanged and column 2*i+1 carries its inverse; bit c of a row word controls column c.
- R3: A row with no programmed bits evaluates to 1.
- R4: A row with both columns of one input programmed evaluates to 0 for either value of that input.
- R5: A product term is the AND of exactly the columns programmed in its row.
- R6: A write with the row address in range replaces that row's bits with the data word. The new value shows in the terms after the next rising clock edge, and the other rows stay unchanged.
- R7: Asserting the clear input returns every row to unprogrammed after the next rising edge. Clear wins over a write in the same cycle.
- R8: A write whose row address is at or beyond the row count changes no row.
- R9: Macrocell m's sum output is the OR of rows 10*m to 10*m+7.
- R10: Macrocell m's reset term is row 10*m+8, and its clock/enable term is row 10*m+9.
- R11: The terms follow input changes combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map write port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_map | input | 1 | Clears the whole connection map |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 8 | Row address of the write |
| wr_data | input | 40 | New connection bits for the addressed row |
| din | input | 20 | Logic inputs to the array |
| pterm | output | 160 | All product terms, bit r is row r |
| mc_sum | output | 16 | Fixed-OR sum per macrocell |
| mc_reset | output | 16 | Asynchronous-reset term per macrocell |
| mc_clkoe | output | 16 | Clock / output-enable term per macrocell |

## Verification
The case that is hardest to reach is a fully loaded map in which the per-macrocell ORs toggle between 0 and 1 under varied inputs. Dense random rows are almost always 0, so the stimulus writes every row with zero to three randomly chosen columns. That keeps each term true often enough that sums, reset terms and clock/enable terms all switch. Contradictory rows, out-of-range addresses and a clear that collides with a write are set up as directed cases, and each is followed by a full comparison of all outputs against a bench-side model of the map.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

  localparam int DEF_INPUTS     = 20;
  localparam int DEF_MACROCELLS = 16;
  localparam int DEF_SUM_TERMS  = 8;

  // role of a row inside its macrocell group
  typedef enum logic [1:0] {
    ROLE_SUM   = 2'd0,
    ROLE_RESET = 2'd1,
    ROLE_CLKOE = 2'd2
  } term_role_e;

  function automatic term_role_e role_of(input int offset, input int n_sum);
    if (offset < n_sum)       return ROLE_SUM;
    else if (offset == n_sum) return ROLE_RESET;
    else                      return ROLE_CLKOE;
  endfunction

endpackage

// File: rtl/pal_rst_sync.sv
`timescale 1ns/1ps
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pal_cfg_store.sv
`timescale 1ns/1ps
module pal_cfg_store #(
  parameter int ROWS  = 160,
  parameter int COLS  = 40,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic [COLS-1:0]            wr_data,
  output logic [ROWS-1:0][COLS-1:0]  map_o
);

  logic [ROWS-1:0][COLS-1:0] map_q;
  logic [ROWS-1:0][COLS-1:0] map_d;
  logic [ROWS-1:0]           row_hit;
  logic [ROWS-1:0]           row_ce;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // address decode: out-of-range addresses match no row
    always_comb begin
      row_hit[r] = wr_en && (wr_row == ROW_W'(r));
      row_ce[r]  = clr || row_hit[r];
      if (clr) map_d[r] = '0;
      else     map_d[r] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         map_q[r] <= '0;
      else if (row_ce[r]) map_q[r] <= map_d[r];
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/pal_rails.sv
`timescale 1ns/1ps
module pal_rails #(
  parameter int INPUTS = 20,
  localparam int COLS  = 2 * INPUTS
) (
  input  logic [INPUTS-1:0] din,
  output logic [COLS-1:0]   cols
);

  for (genvar i = 0; i < INPUTS; i++) begin : g_in
    assign cols[2*i]   = din[i];
    assign cols[2*i+1] = ~din[i];
  end

endmodule

// File: rtl/pal_term_plane.sv
`timescale 1ns/1ps
module pal_term_plane #(
  parameter int ROWS = 160,
  parameter int COLS = 40
) (
  input  logic [ROWS-1:0][COLS-1:0] map_i,
  input  logic [COLS-1:0]           cols,
  output logic [ROWS-1:0]           pterm
);

  // an unprogrammed bit masks its column to 1, so an empty row is 1
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign pterm[r] = &(~map_i[r] | cols);
  end

endmodule

// File: rtl/pal_mc_group.sv
`timescale 1ns/1ps
module pal_mc_group
  import pal_pkg::*;
#(
  parameter int MACROCELLS = 16,
  parameter int SUM_TERMS  = 8,
  localparam int PER_MC    = SUM_TERMS + 2,
  localparam int ROWS      = MACROCELLS * PER_MC
) (
  input  logic [ROWS-1:0]       pterm,
  output logic [MACROCELLS-1:0] sum_o,
  output logic [MACROCELLS-1:0] reset_o,
  output logic [MACROCELLS-1:0] clkoe_o
);

  for (genvar m = 0; m < MACROCELLS; m++) begin : g_mc
    logic [PER_MC-1:0] grp;
    logic [SUM_TERMS-1:0] sum_terms;
    assign grp = pterm[m*PER_MC +: PER_MC];

    for (genvar k = 0; k < PER_MC; k++) begin : g_off
      if (role_of(k, SUM_TERMS) == ROLE_SUM) begin : g_sum
        assign sum_terms[k] = grp[k];
      end else if (role_of(k, SUM_TERMS) == ROLE_RESET) begin : g_rst
        assign reset_o[m] = grp[k];
      end else begin : g_ce
        assign clkoe_o[m] = grp[k];
      end
    end

    assign sum_o[m] = |sum_terms;
  end

endmodule

// File: rtl/pal_and_or_array.sv
`timescale 1ns/1ps
module pal_and_or_array
  import pal_pkg::*;
#(
  parameter int N_INPUTS     = DEF_INPUTS,
  parameter int N_MACROCELLS = DEF_MACROCELLS,
  parameter int N_SUM        = DEF_SUM_TERMS,
  localparam int COLS        = 2 * N_INPUTS,
  localparam int PER_MC      = N_SUM + 2,
  localparam int ROWS        = N_MACROCELLS * PER_MC,
  localparam int ROW_W       = $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_map,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [COLS-1:0]         wr_data,
  input  logic [N_INPUTS-1:0]     din,
  output logic [ROWS-1:0]         pterm,
  output logic [N_MACROCELLS-1:0] mc_sum,
  output logic [N_MACROCELLS-1:0] mc_reset,
  output logic [N_MACROCELLS-1:0] mc_clkoe
);

  logic                      rst_sync_n;
  logic [ROWS-1:0][COLS-1:0] row_map;
  logic [COLS-1:0]           cols;

  pal_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pal_cfg_store #(.ROWS(ROWS), .COLS(COLS)) i_cfg_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr_map),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .map_o   (row_map)
  );

  pal_rails #(.INPUTS(N_INPUTS)) i_rails (
    .din  (din),
    .cols (cols)
  );

  pal_term_plane #(.ROWS(ROWS), .COLS(COLS)) i_plane (
    .map_i (row_map),
    .cols  (cols),
    .pterm (pterm)
  );

  pal_mc_group #(.MACROCELLS(N_MACROCELLS), .SUM_TERMS(N_SUM)) i_group (
    .pterm   (pterm),
    .sum_o   (mc_sum),
    .reset_o (mc_reset),
    .clkoe_o (mc_clkoe)
  );

endmodule

// File: rtl/pal_and_or_array_chk.sv
`timescale 1ns/1ps
module pal_and_or_array_chk #(
  parameter int N_INPUTS     = 20,
  parameter int N_MACROCELLS = 16,
  parameter int N_SUM        = 8,
  localparam int COLS        = 2 * N_INPUTS,
  localparam int PER_MC      = N_SUM + 2,
  localparam int ROWS        = N_MACROCELLS * PER_MC,
  localparam int ROW_W       = $clog2(ROWS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr_map,
  input logic                      wr_en,
  input logic [ROW_W-1:0]          wr_row,
  input logic [COLS-1:0]           wr_data,
  input logic [N_INPUTS-1:0]       din,
  input logic [ROWS-1:0]           pterm,
  input logic [N_MACROCELLS-1:0]   mc_sum,
  input logic [N_MACROCELLS-1:0]   mc_reset,
  input logic [N_MACROCELLS-1:0]   mc_clkoe,
  input logic [ROWS-1:0][COLS-1:0] row_map
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  // R7: a clear leaves only empty rows, so every term is high
  a_r7_clear_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    clr_map |=> (&pterm));

  // R6: an in-range write lands in the addressed row
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_map && (wr_row <= LAST_ROW))
      |=> (row_map[$past(wr_row)] == $past(wr_data)));

  // R8: an out-of-range write leaves the terms alone while inputs hold
  a_r8_bad_row_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_map && (wr_row > LAST_ROW))
      |=> ((din != $past(din)) || (pterm == $past(pterm))));

  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    // R3: an empty row is high
    a_r3_empty_row_high: assert property (@(posedge clk) disable iff (!rst_n)
      (row_map[r] == '0) |-> pterm[r]);
  end

  for (genvar m = 0; m < N_MACROCELLS; m++) begin : g_mc_chk
    // R9: sum is the OR of the group's sum rows
    a_r9_sum_is_or: assert property (@(posedge clk) disable iff (!rst_n)
      mc_sum[m] == (|pterm[m*PER_MC +: N_SUM]));
    // R10: reset and clock/enable terms come from the two last rows
    a_r10_reset_row: assert property (@(posedge clk) disable iff (!rst_n)
      mc_reset[m] == pterm[m*PER_MC + N_SUM]);
    a_r10_clkoe_row: assert property (@(posedge clk) disable iff (!rst_n)
      mc_clkoe[m] == pterm[m*PER_MC + N_SUM + 1]);
  end

endmodule

bind pal_and_or_array pal_and_or_array_chk #(
  .N_INPUTS     (N_INPUTS),
  .N_MACROCELLS (N_MACROCELLS),
  .N_SUM        (N_SUM)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .clr_map  (clr_map),
  .wr_en    (wr_en),
  .wr_row   (wr_row),
  .wr_data  (wr_data),
  .din      (din),
  .pterm    (pterm),
  .mc_sum   (mc_sum),
  .mc_reset (mc_reset),
  .mc_clkoe (mc_clkoe),
  .row_map  (row_map)
);

// File: tb/test_pal_and_or_array.sv
`timescale 1ns/1ps
module test_pal_and_or_array;

  localparam int NI   = 20;
  localparam int NM   = 16;
  localparam int NS   = 8;
  localparam int TPM  = NS + 2;
  localparam int ROWS = NM * TPM;
  localparam int COLS = 2 * NI;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, clr_map, wr_en;
  logic [RW-1:0]   wr_row;
  logic [COLS-1:0] wr_data;
  logic [NI-1:0]   din;
  logic [ROWS-1:0] pterm;
  logic [NM-1:0]   mc_sum, mc_reset, mc_clkoe;

  pal_and_or_array i_pal_and_or_array (
    .clk(clk), .rst_n(rst_n), .clr_map(clr_map), .wr_en(wr_en),
    .wr_row(wr_row), .wr_data(wr_data), .din(din), .pterm(pterm),
    .mc_sum(mc_sum), .mc_reset(mc_reset), .mc_clkoe(mc_clkoe)
  );

  typedef struct {
    logic [ROWS-1:0] pt;
    logic [NM-1:0]   s;
    logic [NM-1:0]   a;
    logic [NM-1:0]   c;
    string           tag;
  } exp_t;

  exp_t            sb_q[$];
  logic [COLS-1:0] shadow [ROWS];
  int              checks = 0;
  int              fails  = 0;
  bit              done   = 0;

  function automatic logic [COLS-1:0] rails(input logic [NI-1:0] v);
    logic [COLS-1:0] r;
    for (int i = 0; i < NI; i++) begin
      r[2*i]   = v[i];
      r[2*i+1] = ~v[i];
    end
    return r;
  endfunction

  // driver side: compute expectation from the bench's own map model
  task automatic push_expect(input string tag);
    exp_t e;
    logic [COLS-1:0] cv;
    cv = rails(din);
    for (int r = 0; r < ROWS; r++) e.pt[r] = &(~shadow[r] | cv);
    for (int m = 0; m < NM; m++) begin
      e.s[m] = |e.pt[m*TPM +: NS];
      e.a[m] = e.pt[m*TPM + NS];
      e.c[m] = e.pt[m*TPM + NS + 1];
    end
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic drive_in(input logic [NI-1:0] v);
    @(negedge clk);
    din = v;
  endtask

  task automatic write_row(input logic [RW-1:0] row, input logic [COLS-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_row = row; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (int'(row) < ROWS) shadow[row] = data;
  endtask

  function automatic logic [COLS-1:0] rand_row();
    logic [COLS-1:0] d = '0;
    int k = $urandom_range(0, 3);
    for (int j = 0; j < k; j++) d[$urandom_range(0, COLS-1)] = 1'b1;
    return d;
  endfunction

  // monitor side: pop and compare away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (pterm !== e.pt) begin
          fails++;
          $display("FAIL %s pterm actual=%h expected=%h", e.tag, pterm, e.pt);
        end
        checks++;
        if (mc_sum !== e.s) begin
          fails++;
          $display("FAIL %s/R9 mc_sum actual=%h expected=%h", e.tag, mc_sum, e.s);
        end
        checks++;
        if (mc_reset !== e.a || mc_clkoe !== e.c) begin
          fails++;
          $display("FAIL %s/R10 reset/clkoe actual=%h/%h expected=%h/%h",
                   e.tag, mc_reset, mc_clkoe, e.a, e.c);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_map = 1'b0; wr_en = 1'b0; wr_row = '0; wr_data = '0;
    din = '0;
    for (int r = 0; r < ROWS; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset leaves everything unprogrammed
    drive_in(NI'($urandom)); push_expect("R1");
    drive_in('1);            push_expect("R1");

    // R2 / R6: true column of input 5 in row 0, inverted in row 1
    write_row(RW'(0), COLS'(1) << 10);
    write_row(RW'(1), COLS'(1) << 11);
    drive_in(NI'(1) << 5);   push_expect("R2 R6");
    drive_in('0);            push_expect("R2 R6");

    // R4: both polarities of input 3 in row 2
    write_row(RW'(2), COLS'(3) << 6);
    drive_in(NI'(1) << 3);   push_expect("R4");
    drive_in('0);            push_expect("R4");

    // R3: rows never written stay high
    drive_in(NI'($urandom)); push_expect("R3");

    // R5 / R6: load a full random map, then vary inputs
    for (int r = 0; r < ROWS; r++) write_row(RW'(r), rand_row());
    for (int n = 0; n < 40; n++) begin
      drive_in(NI'($urandom)); push_expect("R5");
    end

    // R11: inputs alone change outputs, no writes
    for (int n = 0; n < 6; n++) begin
      drive_in(NI'($urandom)); push_expect("R11");
    end

    // R8: writes beyond the last row
    write_row(RW'(ROWS), '1);
    push_expect("R8");
    write_row(RW'(255), '1);
    push_expect("R8");

    // R6: single-row overwrite in the last group, others untouched
    write_row(RW'(ROWS-1), '0);
    write_row(RW'(ROWS-2), COLS'(1) << 1);
    drive_in('0);            push_expect("R6");
    drive_in('1);            push_expect("R6");

    // R7: clear colliding with a write
    @(negedge clk);
    clr_map = 1'b1; wr_en = 1'b1; wr_row = RW'(5); wr_data = '1;
    @(negedge clk);
    clr_map = 1'b0; wr_en = 1'b0;
    for (int r = 0; r < ROWS; r++) shadow[r] = '0;
    drive_in(NI'($urandom)); push_expect("R7");
    drive_in('0);            push_expect("R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule